// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor Core

This block is a very small processor built around one accumulator and one carry flag. It has four instructions, and every instruction names a memory address. Two of them combine the addressed word with the accumulator: a bitwise NOR, or an addition that records the carry-out. A third writes the accumulator to the addressed location. The fourth is the only branch. It jumps to its address when carry is set, and in the same step it clears carry.

Instructions and data share a single synchronous memory. The memory returns read data one cycle after it samples the address, and it writes on the clock edge where the write enable is high. Every instruction takes exactly four cycles, in this order: fetch, decode, operand access, execute. All memory-side outputs come straight from registers. The instruction word is `ADDR_W + 2` bits wide, and data words have the same width.

Top module: `acc4_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_addr` is 0 and `mem_we` is 0. Reset clears the accumulator, the carry and the program counter, so execution restarts at address 0, including when reset arrives in the middle of an instruction.
- R2: An instruction word carries its opcode in the two most significant bits and its operand address in the low `ADDR_W` bits. The opcodes are 00 NOR, 01 ADD, 10 STO and 11 JCC. In the operand-access cycle, `mem_addr` equals the operand address.
- R3: NOR replaces the accumulator with the bitwise NOR of the accumulator and the addressed word. Carry is left unchanged.
- R4: ADD replaces the accumulator with (accumulator + addressed word) modulo 2^DATA_W. Carry takes the carry-out of that sum.
- R5: STO drives the accumulator on `mem_wdata` to the operand address, with `mem_we` high for exactly one cycle.
- R6: JCC with carry set makes the next fetch come from the operand address, and clears carry.
- R7: JCC with carry clear falls through to the next sequential address, and carry stays clear.
- R8: States run fetch, decode, operand, execute, and then back to fetch. `mem_addr` holds the program counter through fetch and decode. After a non-taken instruction the program counter advances by one, modulo 2^ADDR_W.
- R9: `mem_we` is high only in the operand-access cycle of a STO instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | ADDR_W+2 | Read data, valid one cycle after the address is sampled |
| mem_addr | output | ADDR_W | Registered memory address |
| mem_wdata | output | ADDR_W+2 | Registered write data (accumulator) |
| mem_we | output | 1 | Registered write enable |

## Verification
The bound checker watches several things on every cycle: the state order, that a write strobe appears only in a STO operand cycle and lasts one cycle, that JCC always leaves carry clear, the taken and fall-through next addresses, and that NOR leaves carry alone. The accumulator arithmetic is only visible when a STO exposes it, so NOR and ADD results, carry-out from ADD, and a skipped store after a taken jump are shown by the bench. The bench runs a program against an instruction-level reference model, compares the bus on each cycle, and checks the final memory contents. Reset in the middle of an instruction is also covered only by a bench scenario.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  typedef enum logic [1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STO = 2'b10,
    OP_JCC = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'b00,
    ST_DECODE = 2'b01,
    ST_OPER   = 2'b10,
    ST_EXEC   = 2'b11
  } phase_e;
endpackage

// File: rtl/acc4_seq.sv
module acc4_seq
  import acc4_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_FETCH;
    end else begin
      unique case (phase_q)
        ST_FETCH:  phase_q <= ST_DECODE;
        ST_DECODE: phase_q <= ST_OPER;
        ST_OPER:   phase_q <= ST_EXEC;
        default:   phase_q <= ST_FETCH;
      endcase
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] acc_next,
  output logic              carry_next
);
  logic [DATA_W:0] sum;

  assign sum = {1'b0, acc} + {1'b0, operand};

  always_comb begin
    acc_next   = acc;
    carry_next = carry_in;
    unique case (op)
      OP_NOR: acc_next = ~(acc | operand);
      OP_ADD: begin
        acc_next   = sum[DATA_W-1:0];
        carry_next = sum[DATA_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc4_branch.sv
module acc4_branch
  import acc4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  opcode_e           op,
  input  logic              carry,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_next,
  output logic              taken
);
  assign taken   = (op == OP_JCC) && carry;
  assign pc_next = taken ? target : pc + 1'b1;
endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W+1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ADDR_W+1:0]   mem_wdata,
  output logic                mem_we
);
  localparam int DATA_W = ADDR_W + 2;

  phase_e            phase_w;
  opcode_e           op_q;
  logic [ADDR_W-1:0] opnd_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q;
  logic              carry_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;

  logic [DATA_W-1:0] alu_acc;
  logic              alu_carry;
  logic [ADDR_W-1:0] pc_next;
  logic              jump_taken;

  acc4_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_w)
  );

  acc4_alu #(.DATA_W(DATA_W)) u_alu (
    .op         (op_q),
    .acc        (acc_q),
    .operand    (mem_rdata),
    .carry_in   (carry_q),
    .acc_next   (alu_acc),
    .carry_next (alu_carry)
  );

  acc4_branch #(.ADDR_W(ADDR_W)) u_branch (
    .op      (op_q),
    .carry   (carry_q),
    .pc      (pc_q),
    .target  (opnd_q),
    .pc_next (pc_next),
    .taken   (jump_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
      op_q    <= OP_NOR;
      opnd_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      unique case (phase_w)
        ST_FETCH: ;
        ST_DECODE: begin
          op_q   <= opcode_e'(mem_rdata[DATA_W-1 -: 2]);
          opnd_q <= mem_rdata[ADDR_W-1:0];
          addr_q <= mem_rdata[ADDR_W-1:0];
          if (opcode_e'(mem_rdata[DATA_W-1 -: 2]) == OP_STO) begin
            we_q    <= 1'b1;
            wdata_q <= acc_q;
          end
        end
        ST_OPER: we_q <= 1'b0;
        default: begin
          if (op_q == OP_NOR || op_q == OP_ADD) begin
            acc_q   <= alu_acc;
            carry_q <= alu_carry;
          end else if (op_q == OP_JCC) begin
            carry_q <= carry_q & ~jump_taken;
          end
          pc_q   <= pc_next;
          addr_q <= pc_next;
        end
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
endmodule

// File: rtl/acc4_checker.sv
module acc4_checker
  import acc4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input phase_e            phase,
  input opcode_e           op,
  input logic [ADDR_W-1:0] opnd,
  input logic [ADDR_W-1:0] pc,
  input logic              carry
);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == '0 && !mem_we));

  p_fetch_order_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FETCH) |=> (phase == ST_DECODE));

  p_exec_wraps_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC) |=> (phase == ST_FETCH));

  p_we_sto_only_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase == ST_OPER && op == OP_STO));

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_jcc_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op == OP_JCC) |=> !carry);

  p_jcc_target_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op == OP_JCC && carry) |=> (mem_addr == $past(opnd)));

  p_fall_through_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && !(op == OP_JCC && carry)) |=>
      (mem_addr == ADDR_W'($past(pc) + 1'b1)));

  p_nor_keeps_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op == OP_NOR) |=> (carry == $past(carry)));
endmodule

bind acc4_core acc4_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .phase    (phase_w),
  .op       (op_q),
  .opnd     (opnd_q),
  .pc       (pc_q),
  .carry    (carry_q)
);

// File: tb/tb_acc4_core.sv
module tb_acc4_core;
  localparam int AW    = 6;
  localparam int DW    = AW + 2;
  localparam int DEPTH = 1 << AW;
  localparam int AMASK = DEPTH - 1;
  localparam int DMASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem [DEPTH];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  acc4_core #(.ADDR_W(AW)) dut (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // instruction-level reference state
  int    r_pc, r_acc, r_c, r_op, r_opnd, phase;
  string pc_tag;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_reset();
    r_pc = 0; r_acc = 0; r_c = 0; phase = 0; pc_tag = "R1";
  endtask

  task automatic step();
    int m, s;
    case (phase)
      0: begin
        check(pc_tag, "fetch addr", int'(mem_addr), r_pc);
        check("R9", "we in fetch", int'(mem_we), 0);
        r_op   = int'(mem[r_pc]) >> AW;
        r_opnd = int'(mem[r_pc]) & AMASK;
      end
      1: begin
        check("R8", "decode addr", int'(mem_addr), r_pc);
        check("R9", "we in decode", int'(mem_we), 0);
      end
      2: begin
        check("R2", "operand addr", int'(mem_addr), r_opnd);
        if (r_op == 2) begin
          check("R5", "store strobe", int'(mem_we), 1);
          check("R5", "store data", int'(mem_wdata), r_acc);
        end else begin
          check("R9", "no write", int'(mem_we), 0);
        end
      end
      default: begin
        check("R8", "exec addr", int'(mem_addr), r_opnd);
        check("R5", "strobe one cycle", int'(mem_we), 0);
        m = int'(mem[r_opnd]);
        pc_tag = "R8";
        case (r_op)
          0: r_acc = ~(r_acc | m) & DMASK;
          1: begin
            s = r_acc + m;
            r_acc = s & DMASK;
            r_c = (s >> DW) & 1;
          end
          default: ;
        endcase
        if (r_op == 3 && r_c == 1) begin
          r_pc = r_opnd; r_c = 0; pc_tag = "R6";
        end else begin
          if (r_op == 3) pc_tag = "R7";
          r_pc = (r_pc + 1) & AMASK;
        end
      end
    endcase
    phase = (phase + 1) % 4;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    // program: NOR=00xxxxxx ADD=01 STO=10 JCC=11
    mem[0]  = 8'h31; mem[1]  = 8'h30; mem[2]  = 8'hB8; mem[3]  = 8'h72;
    mem[4]  = 8'hB9; mem[5]  = 8'hC8; mem[6]  = 8'hBA; mem[7]  = 8'hBA;
    mem[8]  = 8'hC6; mem[9]  = 8'h31; mem[10] = 8'h70; mem[11] = 8'hC6;
    mem[12] = 8'h71; mem[13] = 8'h73; mem[14] = 8'h30; mem[15] = 8'hD1;
    mem[16] = 8'hBB; mem[17] = 8'hBC; mem[18] = 8'h30;
    mem[6'h30] = 8'h00; mem[6'h31] = 8'hFF; mem[6'h32] = 8'h0F; mem[6'h33] = 8'h01;
    mem[6'h3A] = 8'h55; mem[6'h3B] = 8'h55;

    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset addr", int'(mem_addr), 0);
    check("R1", "reset we", int'(mem_we), 0);
    rst = 1'b0;
    ref_reset();
    repeat (19 * 4) begin
      step();
      @(negedge clk);
    end

    check("R3", "NOR result stored", int'(mem[6'h38]), 8'hFF);
    check("R4", "ADD wrap result stored", int'(mem[6'h39]), 8'h0E);
    check("R6", "skipped store after jump", int'(mem[6'h3A]), 8'h55);
    check("R6", "second skipped store", int'(mem[6'h3B]), 8'h55);
    check("R3", "NOR kept carry for jump", int'(mem[6'h3C]), 8'hFF);

    // reset in the middle of an instruction
    repeat (2) begin
      step();
      @(negedge clk);
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "mid-run reset addr", int'(mem_addr), 0);
    check("R1", "mid-run reset we", int'(mem_we), 0);
    rst = 1'b0;
    ref_reset();
    repeat (6 * 4) begin
      step();
      @(negedge clk);
    end
    check("R3", "rerun NOR result", int'(mem[6'h38]), 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule